// File: doc/BRIEF.md
# Activate Pacing Limiter

This block paces row-activate commands for one memory rank. Two rules apply. The first is a minimum distance in cycles between one activate and the next. That distance is longer when both activates go to the same bank group. The second rule caps how many activates can fall inside any sliding window of a set number of cycles. The scheduler that drives the block reports each activate it issues on a strobe, together with the bank group that activate targets. While no activate is issued, the group input carries the group of the candidate the scheduler is weighing.

The permission output is combinational from registered state and from the candidate group. When it is high, an activate strobed in the same cycle is legal. The window is tracked by a ring of per-activate countdown slots, one slot for each activate the window may hold. An activate strobed while permission is low still updates every timer. It also sets a sticky error flag that only reset clears.

All spacings, the window length, the activate cap and the number of groups are elaboration-time parameters, counted in clock cycles. A window length of zero removes the window rule. A long spacing of zero removes the group distinction.

Top module: `act_pacer`

## Requirements
- R1: After reset, `act_ok` is high for every candidate group and `act_viol` is low.
- R2: After an activate, `act_ok` stays low for any candidate group until RRD_S cycles have passed: an activate sampled at edge N permits the next one no earlier than edge N+RRD_S.
- R3: When RRD_L is nonzero and the candidate group equals the group of the most recent activate, the required distance is RRD_L cycles instead of RRD_S.
- R4: When RRD_L is zero, the group input has no effect, and only RRD_S spacing applies.
- R5: No more than ACT_LIMIT activates are permitted in any XAW consecutive cycles: the activate that follows ACT_LIMIT others is permitted no earlier than XAW cycles after the activate ACT_LIMIT positions before it.
- R6: An ACT_LIMIT of 2 is supported: a third activate waits XAW cycles after the first.
- R7: With XAW equal to zero the window rule is off, and activates spaced by RRD_S are always permitted.
- R8: An activate strobed while `act_ok` is low raises `act_viol` one edge later. `act_viol` then stays high until reset.
- R9: A non-permitted activate is still recorded: spacing restarts from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | An activate is issued this cycle |
| act_group | input | GW | Bank group of the issued or candidate activate |
| act_ok | output | 1 | An activate to `act_group` is legal this cycle |
| act_viol | output | 1 | Sticky: an activate was issued while not permitted |

## Verification
The bench samples permission one cycle before each spacing and window boundary and again on the boundary itself. A timer that is off by one shows up as a wrong value on one side. The bench also asks for the same group and a different group at the same moment. A design that applied the long spacing to every group, or to none, fails one of those two checks. For a violating activate, the bench probes the cycle in which only a recorded violation keeps permission low. A design that dropped the illegal strobe would reopen one cycle early there. Separate instances cover a cap of two, a window switched off and group spacing switched off.

// File: rtl/act_pacer_pkg.sv
package act_pacer_pkg;

    localparam int DEF_RRD_S  = 5;
    localparam int DEF_RRD_L  = 8;
    localparam int DEF_XAW    = 24;
    localparam int DEF_LIMIT  = 4;
    localparam int DEF_GROUPS = 4;

    // width of a counter that must hold values 0 .. v-1
    function automatic int ctr_w(input int v);
        return (v < 3) ? 1 : $clog2(v);
    endfunction

    // width of an index that selects one of n items
    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/act_spacing.sv
module act_spacing
    import act_pacer_pkg::*;
#(
    parameter int RRD_S   = DEF_RRD_S,
    parameter int RRD_L   = DEF_RRD_L,
    parameter int GROUP_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [GROUP_W-1:0] grp,
    output logic               ok
);
    localparam int SPAN = (RRD_S > RRD_L) ? RRD_S : RRD_L;
    localparam int SW   = ctr_w(SPAN);

    logic [SW-1:0] short_cnt;
    logic          long_ok;

    always_ff @(posedge clk) begin
        if (rst)
            short_cnt <= '0;
        else if (fire)
            short_cnt <= SW'(RRD_S - 1);
        else if (short_cnt != '0)
            short_cnt <= short_cnt - 1'b1;
    end

    generate
        if (RRD_S > 1) begin : g_short_chk
            assert_short_hold_R2: assert property (@(posedge clk) disable iff (rst)
                fire |=> (short_cnt != '0));
        end

        if (RRD_L > 0) begin : g_grouped
            logic [SW-1:0]      long_cnt;
            logic [GROUP_W-1:0] last_grp;

            always_ff @(posedge clk) begin
                if (rst) begin
                    long_cnt <= '0;
                    last_grp <= '0;
                end else if (fire) begin
                    long_cnt <= SW'(RRD_L - 1);
                    last_grp <= grp;
                end else if (long_cnt != '0) begin
                    long_cnt <= long_cnt - 1'b1;
                end
            end

            assign long_ok = (grp != last_grp) || (long_cnt == '0);

            if (RRD_L > 1) begin : g_long_chk
                assert_long_hold_R3: assert property (@(posedge clk) disable iff (rst)
                    fire |=> (long_cnt != '0));
            end
        end else begin : g_flat
            assign long_ok = 1'b1;
        end
    endgenerate

    assign ok = (short_cnt == '0) && long_ok;

endmodule

// File: rtl/act_window.sv
module act_window
    import act_pacer_pkg::*;
#(
    parameter int XAW   = DEF_XAW,
    parameter int LIMIT = DEF_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ok
);
    localparam int AW = ctr_w(XAW);
    localparam int PW = idx_w(LIMIT);

    logic [AW-1:0]    ages [LIMIT];
    logic [PW-1:0]    ptr;
    logic [LIMIT-1:0] busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < LIMIT; i++) ages[i] <= '0;
        end else begin
            for (int i = 0; i < LIMIT; i++) begin
                if (fire && (ptr == PW'(i)))
                    ages[i] <= AW'(XAW - 1);
                else if (ages[i] != '0)
                    ages[i] <= ages[i] - 1'b1;
            end
            if (fire)
                ptr <= (ptr == PW'(LIMIT - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < LIMIT; i++) busy[i] = (ages[i] != '0);
    end

    // the slot about to be reused holds the oldest of the recorded activates
    assign ok = (ages[ptr] == '0);

    // a blocked window means every slot is still inside the window
    assert_full_when_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        !ok |-> ($countones(busy) == LIMIT));

endmodule

// File: rtl/act_pacer.sv
module act_pacer
    import act_pacer_pkg::*;
#(
    parameter int RRD_S     = DEF_RRD_S,
    parameter int RRD_L     = DEF_RRD_L,
    parameter int XAW       = DEF_XAW,
    parameter int ACT_LIMIT = DEF_LIMIT,
    parameter int GROUPS    = DEF_GROUPS,
    localparam int GW       = idx_w(GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_valid,
    input  logic [GW-1:0] act_group,
    output logic          act_ok,
    output logic          act_viol
);
    logic space_ok;
    logic win_ok;

    act_spacing #(
        .RRD_S  (RRD_S),
        .RRD_L  (RRD_L),
        .GROUP_W(GW)
    ) u_space (
        .clk (clk),
        .rst (rst),
        .fire(act_valid),
        .grp (act_group),
        .ok  (space_ok)
    );

    generate
        if (XAW > 0) begin : g_window
            act_window #(
                .XAW  (XAW),
                .LIMIT(ACT_LIMIT)
            ) u_win (
                .clk (clk),
                .rst (rst),
                .fire(act_valid),
                .ok  (win_ok)
            );
        end else begin : g_nowindow
            assign win_ok = 1'b1;
        end
    endgenerate

    assign act_ok = space_ok && win_ok;

    always_ff @(posedge clk) begin
        if (rst)
            act_viol <= 1'b0;
        else if (act_valid && !act_ok)
            act_viol <= 1'b1;
    end

    assert_viol_set_R8: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !act_ok) |=> act_viol);

    assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        act_viol |=> act_viol);

    assert_legal_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_ok && !act_viol) |=> !act_viol);

endmodule

// File: tb/sim_act_pacer.sv
module sim_act_pacer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    logic       av0 = 0, av1 = 0, av2 = 0;
    logic [1:0] g0 = 0, g1 = 0, g2 = 0;
    logic       ok0, ok1, ok2, v0, v1, v2;

    // grouped, window 24, cap 4
    act_pacer #(.RRD_S(5), .RRD_L(8), .XAW(24), .ACT_LIMIT(4), .GROUPS(4)) u0 (
        .clk(clk), .rst(rst), .act_valid(av0), .act_group(g0), .act_ok(ok0), .act_viol(v0));
    // no groups, window 20, cap 2
    act_pacer #(.RRD_S(5), .RRD_L(0), .XAW(20), .ACT_LIMIT(2), .GROUPS(4)) u1 (
        .clk(clk), .rst(rst), .act_valid(av1), .act_group(g1), .act_ok(ok1), .act_viol(v1));
    // window off
    act_pacer #(.RRD_S(5), .RRD_L(0), .XAW(0), .ACT_LIMIT(4), .GROUPS(4)) u2 (
        .clk(clk), .rst(rst), .act_valid(av2), .act_group(g2), .act_ok(ok2), .act_viol(v2));

    task automatic check(input string req, input logic got, input logic exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; av0 = 0; av1 = 0; av2 = 0;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic act0(input logic [1:0] g);
        g0 = g; av0 = 1'b1;
        @(negedge clk);
        av0 = 1'b0;
    endtask

    task automatic act1(input logic [1:0] g);
        g1 = g; av1 = 1'b1;
        @(negedge clk);
        av1 = 1'b0;
    endtask

    task automatic act2();
        av2 = 1'b1;
        @(negedge clk);
        av2 = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int g = 0; g < 4; g++) begin
            g0 = 2'(g); #1;
            check("R1 ok after reset", ok0, 1'b1);
        end
        check("R1 viol after reset", v0, 1'b0);
    endtask

    task automatic t_spacing();
        do_reset();
        act0(2'd1);                    // edge P0
        idle(3); g0 = 2'd2; #1;
        check("R2 other group before RRD_S", ok0, 1'b0);
        idle(1); g0 = 2'd2; #1;
        check("R2 other group at RRD_S", ok0, 1'b1);
        g0 = 2'd1; #1;
        check("R3 same group at RRD_S", ok0, 1'b0);
        idle(2); #1;
        check("R3 same group before RRD_L", ok0, 1'b0);
        idle(1); #1;
        check("R3 same group at RRD_L", ok0, 1'b1);
    endtask

    task automatic t_window();
        do_reset();
        act0(2'd0); idle(4);
        act0(2'd1); idle(4);
        act0(2'd2); idle(4);
        act0(2'd3);                    // fourth activate at P15
        idle(4); g0 = 2'd0; #1;
        check("R5 fifth blocked by window", ok0, 1'b0);
        idle(3); #1;
        check("R5 fifth one cycle early", ok0, 1'b0);
        idle(1); #1;
        check("R5 fifth at window end", ok0, 1'b1);
        check("R5 legal sequence no viol", v0, 1'b0);
    endtask

    task automatic t_viol();
        do_reset();
        act0(2'd0);
        act0(2'd1);                    // illegal, one cycle later
        check("R8 viol raised", v0, 1'b1);
        idle(3); g0 = 2'd2; #1;
        check("R9 spacing restarted by illegal act", ok0, 1'b0);
        idle(1); #1;
        check("R9 reopens after illegal act", ok0, 1'b1);
        idle(30);
        check("R8 viol sticky", v0, 1'b1);
        do_reset();
        check("R8 viol cleared by reset", v0, 1'b0);
    endtask

    task automatic t_limit2();
        do_reset();
        act1(2'd1);                    // P0
        idle(4); g1 = 2'd1; #1;
        check("R4 same group uses short spacing", ok1, 1'b1);
        act1(2'd1);                    // P5
        idle(13); #1;
        check("R6 third blocked", ok1, 1'b0);
        idle(1); #1;
        check("R6 third at window end", ok1, 1'b1);
        check("R6 no viol", v1, 1'b0);
    endtask

    task automatic t_nowin();
        do_reset();
        for (int k = 0; k < 6; k++) begin
            #1;
            check("R7 permitted without window", ok2, 1'b1);
            act2();
            idle(4);
        end
        check("R7 no viol", v2, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_spacing();
        t_window();
        t_viol();
        t_limit2();
        t_nowin();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule